// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block builds the byte that a bus read returns while a self-timed program or erase algorithm is running inside a nonvolatile memory. An internal algorithm sequencer tells it when a byte program or a sector erase starts, when each internal program or erase pulse is issued, and when the algorithm finishes. The block then answers read strobes from the bus. While no operation is active, it passes array data through. While an operation is active, it returns a status byte. That byte has four meaningful bits:
- a data-poll bit that shows the inverse of the target bit until completion;
- a toggle bit that flips on every status read;
- a sticky timeout bit that is set when the pulse budget is exceeded;
- an erase-window bit.

When a sector erase is started, the block opens an acceptance window of parameterised length. Further sector erase commands that arrive inside the window are acknowledged, and each one restarts the window. When the window expires, the erase proper begins and later sector commands are dropped. If an operation uses more pulses than its limit, the block enters a lockout state. In lockout only status reporting works, and only a reset command returns the block to normal reads.

Top module: `embop_status`

## Requirements
- R1: With no operation active, a read strobe returns `arr_data` on `rd_data` one clock later, unchanged.
- R2: While a program is active, status bit 7 is the inverse of bit 7 of the latched target byte. While an erase is active it is 0. Bits 4, 2, 1 and 0 of the status byte read 0.
- R3: Each status read while busy returns bit 6 opposite to the previous status read. The first one after reset returns 0. Reads while idle leave the toggle untouched.
- R4: An operation may take up to `PULSE_MAX` pulses. The next pulse sets status bit 5 and places the block in lockout. `busy` stays 1 and bit 5 reads 1.
- R5: In lockout, `op_done`, start commands and sector commands have no effect. Only `op_reset_cmd` leaves lockout, after which reads return array data.
- R6: After an erase start, status bit 3 reads 0 for `WIN_LEN` cycles. From then until the erase ends, it reads 1.
- R7: A sector command inside the window raises `sect_ack` for one cycle and restarts the window length. Once bit 3 is 1, a sector command gives no `sect_ack` and bit 3 stays 1.
- R8: `op_done` during a program or a running erase ends the operation. `busy` falls and the next read returns array data.
- R9: Start commands that arrive while an operation is active are ignored. The latched target bit and the operation type are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start_prog | input | 1 | Byte program algorithm starts (pulse) |
| op_start_erase | input | 1 | Sector erase sequence completed (pulse) |
| op_add_sector | input | 1 | Additional sector erase command written (pulse) |
| op_pulse | input | 1 | One internal program/erase pulse issued |
| op_done | input | 1 | Sequencer finished the operation |
| op_reset_cmd | input | 1 | Reset command decoded |
| rd_stb | input | 1 | Bus read strobe |
| prog_data | input | DW | Target byte of the program operation |
| arr_data | input | DW | Array read data |
| rd_data | output | DW | Registered read result |
| busy | output | 1 | An operation or lockout is active |
| sect_ack | output | 1 | Sector command accepted into the window |

## Verification
The bench sends the pulse that lands exactly at the limit and then the pulse that goes one past it. A design with an off-by-one counter either fails one pulse early or never fails at all. It writes a sector command two cycles before the window would close and then reads on both sides of the restarted expiry. A timer that does not reload shows bit 3 too early, and a timer that reloads in the wrong state acknowledges late commands. The bench also tries every exit from lockout other than the reset command, and mixes in idle reads between busy reads. A toggle that flips on idle reads, or a lockout that leaks on `op_done`, breaks the expected byte.

// File: rtl/embop_pkg.sv
package embop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PROG = 3'd1,
    ST_EWIN = 3'd2,
    ST_ERUN = 3'd3,
    ST_FAIL = 3'd4
  } embop_state_t;

  // status byte bit positions (software decodes these)
  localparam int unsigned POLL_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;
  localparam int unsigned TMO_BIT  = 5;
  localparam int unsigned WIN_BIT  = 3;
endpackage

// File: rtl/embop_win_timer.sv
module embop_win_timer #(
  parameter int unsigned WIN_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(WIN_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run && !load && (cnt_q == '0);
endmodule

// File: rtl/embop_pulse_limit.sv
module embop_pulse_limit #(
  parameter int unsigned PULSE_MAX = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic over
);
  localparam int unsigned CW = $clog2(PULSE_MAX + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PULSE_MAX);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign over = inc && (cnt_q == LIMIT);
endmodule

// File: rtl/embop_stat_byte.sv
module embop_stat_byte
  import embop_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  embop_state_t   st,
  input  logic           tgt_msb,
  input  logic           erase_op,
  input  logic           tog,
  output logic [DW-1:0]  status
);
  always_comb begin
    status           = '0;
    status[POLL_BIT] = erase_op ? 1'b0 : ~tgt_msb;
    status[TOG_BIT]  = tog;
    status[TMO_BIT]  = (st == ST_FAIL);
    status[WIN_BIT]  = (st == ST_ERUN) || (st == ST_FAIL && erase_op);
  end
endmodule

// File: rtl/embop_status.sv
module embop_status
  import embop_pkg::*;
#(
  parameter int unsigned DW        = 8,
  parameter int unsigned WIN_LEN   = 16,
  parameter int unsigned PULSE_MAX = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start_prog,
  input  logic          op_start_erase,
  input  logic          op_add_sector,
  input  logic          op_pulse,
  input  logic          op_done,
  input  logic          op_reset_cmd,
  input  logic          rd_stb,
  input  logic [DW-1:0] prog_data,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          busy,
  output logic          sect_ack
);
  embop_state_t st_q, st_d;
  logic tgt_msb_q, erase_q, tog_q;
  logic win_load, win_run, win_exp;
  logic pl_clr, pl_inc, pl_over;
  logic [DW-1:0] stat_byte;

  assign win_load = (st_q == ST_IDLE && op_start_erase && !op_start_prog) ||
                    (st_q == ST_EWIN && op_add_sector);
  assign win_run  = (st_q == ST_EWIN);
  assign pl_clr   = (st_q == ST_IDLE);
  assign pl_inc   = op_pulse && (st_q == ST_PROG || st_q == ST_ERUN);

  embop_win_timer #(.WIN_LEN(WIN_LEN)) u_win (
    .clk(clk), .rst(rst), .load(win_load), .run(win_run), .expired(win_exp)
  );

  embop_pulse_limit #(.PULSE_MAX(PULSE_MAX)) u_plim (
    .clk(clk), .rst(rst), .clr(pl_clr), .inc(pl_inc), .over(pl_over)
  );

  embop_stat_byte #(.DW(DW)) u_sb (
    .st(st_q), .tgt_msb(tgt_msb_q), .erase_op(erase_q), .tog(tog_q), .status(stat_byte)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (op_start_prog)       st_d = ST_PROG;
        else if (op_start_erase) st_d = ST_EWIN;
      end
      ST_PROG, ST_ERUN: begin
        if (pl_over)      st_d = ST_FAIL;
        else if (op_done) st_d = ST_IDLE;
      end
      ST_EWIN: begin
        if (win_exp) st_d = ST_ERUN;
      end
      ST_FAIL: begin
        if (op_reset_cmd) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      tgt_msb_q <= 1'b0;
      erase_q   <= 1'b0;
      tog_q     <= 1'b0;
      rd_data   <= '0;
      sect_ack  <= 1'b0;
    end else begin
      st_q     <= st_d;
      sect_ack <= (st_q == ST_EWIN) && op_add_sector;
      if (st_q == ST_IDLE && op_start_prog) begin
        tgt_msb_q <= prog_data[DW-1];
        erase_q   <= 1'b0;
      end else if (st_q == ST_IDLE && op_start_erase) begin
        erase_q   <= 1'b1;
      end
      if (rd_stb) begin
        if (st_q != ST_IDLE) begin
          rd_data <= stat_byte;
          tog_q   <= ~tog_q;
        end else begin
          rd_data <= arr_data;
        end
      end
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/embop_status_chk.sv
module embop_status_chk
  import embop_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_stb,
  input logic          busy,
  input logic          sect_ack,
  input logic          op_add_sector,
  input logic          op_reset_cmd,
  input logic [DW-1:0] arr_data,
  input logic [DW-1:0] rd_data,
  input embop_state_t  st
);
  p_idle_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !busy) |=> (rd_data == $past(arr_data)));

  p_tog_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && busy && $past(rd_stb && busy) && !$past(rst)) |=>
      (rd_data[TOG_BIT] != $past(rd_data[TOG_BIT])));

  p_fail_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st == ST_FAIL) |=> rd_data[TMO_BIT]);

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_FAIL && !op_reset_cmd) |=> (st == ST_FAIL));

  p_win_open_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st == ST_EWIN) |=> !rd_data[WIN_BIT]);

  p_win_closed_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st == ST_ERUN) |=> rd_data[WIN_BIT]);

  p_ack_window_r7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_EWIN || !op_add_sector) |=> !sect_ack);
endmodule

bind embop_status embop_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_stb(rd_stb), .busy(busy), .sect_ack(sect_ack),
  .op_add_sector(op_add_sector), .op_reset_cmd(op_reset_cmd),
  .arr_data(arr_data), .rd_data(rd_data), .st(st_q)
);

// File: tb/embop_status_tb_top.sv
module embop_status_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned W  = 8;
  localparam int unsigned PM = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_start_prog = 0, op_start_erase = 0, op_add_sector = 0;
  logic op_pulse = 0, op_done = 0, op_reset_cmd = 0, rd_stb = 0;
  logic [DW-1:0] prog_data = '0, arr_data = '0;
  logic [DW-1:0] rd_data;
  logic busy, sect_ack;

  int n_run = 0, n_fail = 0;
  logic tog_m = 1'b0;

  always #2 clk = ~clk;

  embop_status #(.DW(DW), .WIN_LEN(W), .PULSE_MAX(PM)) dut_i (
    .clk(clk), .rst(rst), .op_start_prog(op_start_prog), .op_start_erase(op_start_erase),
    .op_add_sector(op_add_sector), .op_pulse(op_pulse), .op_done(op_done),
    .op_reset_cmd(op_reset_cmd), .rd_stb(rd_stb), .prog_data(prog_data),
    .arr_data(arr_data), .rd_data(rd_data), .busy(busy), .sect_ack(sect_ack)
  );

  function automatic logic [7:0] exp_stat(logic poll, logic tg, logic tmo, logic win);
    logic [7:0] b = '0;
    b[7] = poll; b[6] = tg; b[5] = tmo; b[3] = win;
    return b;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(output logic [7:0] v);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic rd_busy(input string req, input logic poll, input logic tmo, input logic win);
    logic [7:0] v;
    rd(v);
    chk(req, v, exp_stat(poll, tog_m, tmo, win));
    tog_m = ~tog_m;
  endtask

  task automatic rd_idle(input string req);
    logic [7:0] v, a;
    a = 8'($urandom);
    arr_data = a;
    rd(v);
    chk(req, v, a);
  endtask

  task automatic start_prog(input logic [7:0] d);
    prog_data = d; op_start_prog = 1'b1; @(negedge clk); op_start_prog = 1'b0;
  endtask
  task automatic start_erase();
    op_start_erase = 1'b1; @(negedge clk); op_start_erase = 1'b0;
  endtask
  task automatic pulse();
    op_pulse = 1'b1; @(negedge clk); op_pulse = 1'b0;
  endtask
  task automatic done();
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
  endtask
  task automatic add_sect(output logic ack);
    op_add_sector = 1'b1; @(negedge clk); op_add_sector = 1'b0; ack = sect_ack;
  endtask
  task automatic reset_cmd();
    op_reset_cmd = 1'b1; @(negedge clk); op_reset_cmd = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] t;
    void'($urandom(32'd1234));
    tick(3);
    rst = 1'b0;
    chk("reset busy", {7'd0, busy}, 8'd0);
    chk("reset rd_data", rd_data, 8'd0);
    rd_idle("R1 idle pass");
    rd_idle("R1 idle pass 2");

    // R2/R3/R9 program, start while busy ignored
    start_prog(8'h80);
    rd_busy("R2 prog poll", 1'b0, 1'b0, 1'b0);
    start_prog(8'h00);
    start_erase();
    rd_busy("R9 start ignored", 1'b0, 1'b0, 1'b0);
    rd_busy("R3 toggle flips", 1'b0, 1'b0, 1'b0);
    // R4 exactly PULSE_MAX pulses is fine
    for (int i = 0; i < PM; i++) pulse();
    rd_busy("R4 at limit", 1'b0, 1'b0, 1'b0);
    pulse();
    rd_busy("R4 over limit", 1'b0, 1'b1, 1'b0);
    // R5 lockout leaks
    done();
    start_erase();
    add_sect(ack);
    chk("R5 no ack in lockout", {7'd0, ack}, 8'd0);
    rd_busy("R5 lockout held", 1'b0, 1'b1, 1'b0);
    chk("R5 busy in lockout", {7'd0, busy}, 8'd1);
    reset_cmd();
    chk("R5 reset cmd exits", {7'd0, busy}, 8'd0);
    rd_idle("R5 array after reset");

    // R6/R7 erase window with restart
    start_erase();
    rd_busy("R6 window open", 1'b0, 1'b0, 1'b0);   // read at edge e+1
    tick(W - 4);                                   // up to edge e+W-3
    add_sect(ack);                                 // edge e+W-2
    chk("R7 ack in window", {7'd0, ack}, 8'd1);
    tick(W - 3);
    rd_busy("R7 window restarted", 1'b0, 1'b0, 1'b0);
    tick(2);
    rd_busy("R6 window closed", 1'b0, 1'b0, 1'b1);
    add_sect(ack);
    chk("R7 no ack when running", {7'd0, ack}, 8'd0);
    rd_busy("R7 bit3 stays", 1'b0, 1'b0, 1'b1);
    for (int i = 0; i <= PM; i++) pulse();
    rd_busy("R4 erase over limit", 1'b0, 1'b1, 1'b1);
    reset_cmd();
    rd_idle("R5 idle after erase fail");

    // random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom % 3)
        0: rd_idle("R1 random idle");
        1: begin
          t = 8'($urandom);
          start_prog(t);
          for (int p = 0; p < int'($urandom % (PM + 1)); p++) begin
            if ($urandom % 2) rd_busy("R2 random prog", ~t[7], 1'b0, 1'b0);
            pulse();
          end
          rd_busy("R3 random prog", ~t[7], 1'b0, 1'b0);
          done();
          chk("R8 prog done", {7'd0, busy}, 8'd0);
          rd_idle("R8 after prog");
        end
        default: begin
          start_erase();
          rd_busy("R6 random window", 1'b0, 1'b0, 1'b0);
          tick(W);
          rd_busy("R6 random run", 1'b0, 1'b0, 1'b1);
          for (int p = 0; p < int'($urandom % (PM + 1)); p++) pulse();
          done();
          chk("R8 erase done", {7'd0, busy}, 8'd0);
          rd_idle("R8 after erase");
        end
      endcase
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule